// File: doc/BRIEF.md
# Carry-Select Arithmetic Register Cluster

A group of arithmetic bit cells, ten bits wide by default, that works as an adder/subtractor, a loadable up/down counter or an accumulator. Each bit forms two candidate sum bits. One assumes its incoming carry is 0 and the other assumes it is 1. Each bit also forms a carry-out on two parallel carry chains, one seeded with 0 at bit 0 and one seeded with 1. A group-level carry selection decides which chain's carry pattern picks the final sum bits. No single ripple chain ever decides the result.

Every bit has a combinational result output and a registered copy of it. The register stage has these controls:
- a clock enable;
- a counting enable;
- group-wide synchronous clear and load;
- up/down direction for counter use.

Operand a comes either from an external data port or from the register's own value. Operand b is an external data word, or +1 / -1 in counter use. Both chain carry-outs are exported so that a following group can make its own selection.

Top module: `csa_cluster`

## Requirements
- R1: With add_sub=0 and cnt_mode=0, sum_comb equals (A + B + carry_in) mod 2^W and carry_out equals bit W of that sum. A is data_a when fb_sel=0 and sum_q when fb_sel=1. B is data_b.
- R2: With add_sub=1 and cnt_mode=0, sum_comb equals (A - B) mod 2^W and carry_out equals 1 exactly when A >= B (unsigned). In this case carry_in has no effect.
- R3: co_chain0 is bit W of A + B' + 0, and co_chain1 is bit W of A + B' + 1. B' is the effective operand b: data_b, or its bitwise inverse when subtracting, or the counter step.
- R4: On a rising clk edge with clk_en=1, cnt_en=1, sclr=0 and sload=0, sum_q takes the value sum_comb had before the edge.
- R5: On a rising edge with clk_en=1 and sclr=1, sum_q becomes 0, whatever sload and cnt_en are.
- R6: On a rising edge with clk_en=1, sclr=0 and sload=1, sum_q becomes load_val, whatever cnt_en is.
- R7: On a rising edge with clk_en=0, sum_q keeps its value, even with sclr, sload or cnt_en high.
- R8: On a rising edge with clk_en=1, sclr=0, sload=0 and cnt_en=0, sum_q keeps its value.
- R9: With cnt_mode=1 and fb_sel=1, the block counts. up_dn=1 adds 1 to sum_q and up_dn=0 subtracts 1, both wrapping modulo 2^W. add_sub and carry_in have no effect in this mode.
- R10: With cnt_mode=0 and fb_sel=1, the block accumulates. Each enabled edge replaces sum_q with sum_q + data_b (add_sub=0, plus carry_in) or with sum_q - data_b (add_sub=1).
- R11: While rst_n is low, sum_q is 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Register clock enable; gates every register action |
| cnt_en | input | 1 | Lets the arithmetic result into the register |
| sclr | input | 1 | Group-wide synchronous clear |
| sload | input | 1 | Group-wide synchronous load |
| load_val | input | W | Value for synchronous load |
| add_sub | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Group carry selection while adding |
| fb_sel | input | 1 | 1 = operand a is sum_q, 0 = operand a is data_a |
| cnt_mode | input | 1 | 1 = operand b is the counter step |
| up_dn | input | 1 | Counter direction, 1 = up |
| data_a | input | W | External operand a |
| data_b | input | W | External operand b |
| sum_comb | output | W | Combinational result |
| carry_out | output | 1 | Carry-out of the selected chain |
| co_chain0 | output | 1 | Carry-out of the chain seeded with 0 |
| co_chain1 | output | 1 | Carry-out of the chain seeded with 1 |
| sum_q | output | W | Registered result |

## Verification
The clocked properties assume that every control and data input is free of unknowns and holds still across each rising edge. They also assume the combinational result has settled by that edge. The bench keeps to this by changing inputs only on falling edges and reading outputs half a cycle after the edge that updates them. The counter-step property also takes for granted that fb_sel is high whenever cnt_mode is, because a step applied to data_a would not be a count. The bench only enters counter use with both set.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Carry out of one bit, given the carry arriving on that chain.
  function automatic logic chain_carry(input logic cin, input logic a, input logic b);
    return cin ? (a | b) : (a & b);
  endfunction

  // Both speculative sum bits of one cell: {assume carry 1, assume carry 0}.
  function automatic logic [1:0] spec_sums(input logic a, input logic b);
    return {~(a ^ b), (a ^ b)};
  endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell
  import csa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci0,
  input  logic ci1,
  input  logic pick,
  output logic co0,
  output logic co1,
  output logic s
);
  logic [1:0] cand;
  logic       used_carry;

  always_comb begin
    cand       = spec_sums(a, b);
    co0        = chain_carry(ci0, a, b);
    co1        = chain_carry(ci1, a, b);
    used_carry = pick ? ci1 : ci0;
    s          = used_carry ? cand[1] : cand[0];
  end
endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int W = 10
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         pick,
  output logic [W-1:0] sum,
  output logic         co0,
  output logic         co1,
  output logic         co
);
  logic [W:0] c0;
  logic [W:0] c1;

  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_cell u_cell (
      .a    (op_a[i]),
      .b    (op_b[i]),
      .ci0  (c0[i]),
      .ci1  (c1[i]),
      .pick (pick),
      .co0  (c0[i+1]),
      .co1  (c1[i+1]),
      .s    (sum[i])
    );
  end

  assign co0 = c0[W];
  assign co1 = c1[W];
  assign co  = pick ? c1[W] : c0[W];
endmodule

// File: rtl/csa_operand.sv
module csa_operand #(
  parameter int W = 10
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] data_a,
  input  logic [W-1:0] data_b,
  input  logic         fb_sel,
  input  logic         cnt_mode,
  input  logic         up_dn,
  input  logic         add_sub,
  input  logic         carry_in,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b,
  output logic         pick
);
  localparam logic [W-1:0] STEP_UP = W'(1);
  localparam logic [W-1:0] STEP_DN = '1;

  logic sub_eff;

  always_comb begin
    sub_eff = add_sub & ~cnt_mode;
    op_a    = fb_sel ? q : data_a;
    if (cnt_mode)     op_b = up_dn ? STEP_UP : STEP_DN;
    else if (sub_eff) op_b = ~data_b;
    else              op_b = data_b;
    if (cnt_mode)     pick = 1'b0;
    else if (sub_eff) pick = 1'b1;
    else              pick = carry_in;
  end
endmodule

// File: rtl/csa_reg.sv
module csa_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         cnt_en,
  input  logic         sclr,
  input  logic         sload,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic do_clr, do_load, do_step;

  assign do_clr  = clk_en & sclr;
  assign do_load = clk_en & ~sclr & sload;
  assign do_step = clk_en & ~sclr & ~sload & cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (do_clr)  q <= '0;
    else if (do_load) q <= load_val;
    else if (do_step) q <= d;
  end

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sclr) |=> (q == '0));
  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sclr && sload) |=> (q == $past(load_val)));
  a_r7_ce_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(q));
  a_r8_cnt_en_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sclr && !sload && !cnt_en) |=> $stable(q));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sclr && !sload && cnt_en) |=> (q == $past(d)));
endmodule

// File: rtl/csa_cluster.sv
module csa_cluster #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         cnt_en,
  input  logic         sclr,
  input  logic         sload,
  input  logic [W-1:0] load_val,
  input  logic         add_sub,
  input  logic         carry_in,
  input  logic         fb_sel,
  input  logic         cnt_mode,
  input  logic         up_dn,
  input  logic [W-1:0] data_a,
  input  logic [W-1:0] data_b,
  output logic [W-1:0] sum_comb,
  output logic         carry_out,
  output logic         co_chain0,
  output logic         co_chain1,
  output logic [W-1:0] sum_q
);
  logic [W-1:0] op_a, op_b;
  logic         pick;

  csa_operand #(.W(W)) u_operand (
    .q        (sum_q),
    .data_a   (data_a),
    .data_b   (data_b),
    .fb_sel   (fb_sel),
    .cnt_mode (cnt_mode),
    .up_dn    (up_dn),
    .add_sub  (add_sub),
    .carry_in (carry_in),
    .op_a     (op_a),
    .op_b     (op_b),
    .pick     (pick)
  );

  csa_chain #(.W(W)) u_chain (
    .op_a (op_a),
    .op_b (op_b),
    .pick (pick),
    .sum  (sum_comb),
    .co0  (co_chain0),
    .co1  (co_chain1),
    .co   (carry_out)
  );

  csa_reg #(.W(W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .cnt_en   (cnt_en),
    .sclr     (sclr),
    .sload    (sload),
    .load_val (load_val),
    .d        (sum_comb),
    .q        (sum_q)
  );

  // Integer references for the two speculative chains.
  logic [W:0] ref_sel, ref_c0, ref_c1;
  assign ref_c0  = {1'b0, op_a} + {1'b0, op_b};
  assign ref_c1  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, 1'b1};
  assign ref_sel = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, pick};

  a_r1_selected_sum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ({carry_out, sum_comb} == ref_sel));
  a_r3_chain_carries: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (co_chain0 == ref_c0[W] && co_chain1 == ref_c1[W]));
  a_r3_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
    co_chain0 |-> co_chain1);
  a_r2_borrow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (add_sub && !cnt_mode) |-> (carry_out == (op_a >= data_b)));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && fb_sel && clk_en && cnt_en && !sclr && !sload)
      |=> (sum_q == ($past(up_dn) ? $past(sum_q) + W'(1) : $past(sum_q) - W'(1))));
endmodule

// File: tb/csa_cluster_tb.sv
module csa_cluster_tb;
  localparam int W    = 10;
  localparam int MODV = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0, cnt_en = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic add_sub = 1'b0, carry_in = 1'b0, fb_sel = 1'b0, cnt_mode = 1'b0, up_dn = 1'b1;
  logic [W-1:0] load_val = '0, data_a = '0, data_b = '0;
  logic [W-1:0] sum_comb, sum_q;
  logic carry_out, co_chain0, co_chain1;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  csa_cluster #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cnt_en(cnt_en),
    .sclr(sclr), .sload(sload), .load_val(load_val), .add_sub(add_sub),
    .carry_in(carry_in), .fb_sel(fb_sel), .cnt_mode(cnt_mode), .up_dn(up_dn),
    .data_a(data_a), .data_b(data_b), .sum_comb(sum_comb), .carry_out(carry_out),
    .co_chain0(co_chain0), .co_chain1(co_chain1), .sum_q(sum_q)
  );

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic         sub;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{10'd0,    10'd0,    1'b0, 1'b0},
    '{10'd1023, 10'd1,    1'b0, 1'b0},
    '{10'd1023, 10'd0,    1'b1, 1'b0},
    '{10'd512,  10'd512,  1'b0, 1'b0},
    '{10'd1023, 10'd1023, 1'b1, 1'b0},
    '{10'd300,  10'd200,  1'b0, 1'b1},
    '{10'd200,  10'd300,  1'b0, 1'b1},
    '{10'd0,    10'd0,    1'b0, 1'b1},
    '{10'd5,    10'd5,    1'b1, 1'b1},
    '{10'd341,  10'd682,  1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bb, c, s, ea, eb;
    #20;
    chk("R11 reset state", int'(sum_q), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Combinational table: R1 (add), R2 (subtract), R3 (chain carries)
    for (int i = 0; i < 10; i++) begin
      data_a = VEC[i].a; data_b = VEC[i].b;
      carry_in = VEC[i].cin; add_sub = VEC[i].sub;
      #1;
      ea = int'(VEC[i].a); eb = int'(VEC[i].b);
      bb = VEC[i].sub ? (MODV - 1 - eb) : eb;
      c  = VEC[i].sub ? 1 : int'(VEC[i].cin);
      s  = ea + bb + c;
      chk(VEC[i].sub ? "R2 sum" : "R1 sum", int'(sum_comb), s % MODV);
      chk(VEC[i].sub ? "R2 carry_out" : "R1 carry_out", int'(carry_out), s / MODV);
      chk("R3 co_chain0", int'(co_chain0), (ea + bb) / MODV);
      chk("R3 co_chain1", int'(co_chain1), (ea + bb + 1) / MODV);
      if (VEC[i].sub) chk("R2 no-borrow flag", int'(carry_out), (ea >= eb) ? 1 : 0);
      @(negedge clk);
    end

    // R4: plain adder result captured
    add_sub = 0; carry_in = 0; data_a = 10'd100; data_b = 10'd23;
    clk_en = 1; cnt_en = 1;
    tick();
    chk("R4 capture", int'(sum_q), 123);

    // R8: cnt_en low holds
    cnt_en = 0; data_a = 10'd900;
    tick();
    chk("R8 hold cnt_en low", int'(sum_q), 123);

    // R7: clk_en low holds even with clear/load/count
    clk_en = 0; sclr = 1; sload = 1; cnt_en = 1; load_val = 10'd777;
    tick();
    chk("R7 hold clk_en low", int'(sum_q), 123);

    // R6: load beats counting
    clk_en = 1; sclr = 0; sload = 1; load_val = 10'd700;
    tick();
    chk("R6 load", int'(sum_q), 700);

    // R5: clear beats load
    sclr = 1; sload = 1;
    tick();
    chk("R5 clear priority", int'(sum_q), 0);
    sclr = 0;

    // R9: counter up with wrap, add_sub and carry_in have no effect
    sload = 1; load_val = 10'd1021;
    tick();
    sload = 0; fb_sel = 1; cnt_mode = 1; up_dn = 1; add_sub = 1; carry_in = 1;
    #1;
    chk("R9 comb step", int'(sum_comb), 1022);
    tick(); chk("R9 up 1022", int'(sum_q), 1022);
    tick(); chk("R9 up 1023", int'(sum_q), 1023);
    tick(); chk("R9 up wrap", int'(sum_q), 0);
    up_dn = 0;
    tick(); chk("R9 down wrap", int'(sum_q), 1023);
    tick(); chk("R9 down 1022", int'(sum_q), 1022);

    // R10: accumulator
    cnt_mode = 0; add_sub = 0; carry_in = 0; sload = 1; load_val = 10'd10;
    tick();
    sload = 0; data_b = 10'd5;
    tick(); chk("R10 acc add", int'(sum_q), 15);
    tick(); chk("R10 acc add", int'(sum_q), 20);
    add_sub = 1;
    tick(); chk("R10 acc sub", int'(sum_q), 15);
    add_sub = 0; carry_in = 1;
    tick(); chk("R10 acc add carry", int'(sum_q), 21);

    // R11: asynchronous reset mid-run
    rst_n = 0;
    #1;
    chk("R11 async reset", int'(sum_q), 0);
    @(negedge clk);
    rst_n = 1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule